// File: doc/BRIEF.md
# Sidetone Control and Coefficient Loader

This block is the register front end of an audio sidetone core. A simple 32-bit register bus with address, write strobe, write data and combinational read data reaches a small set of registers. These registers hold the sidetone on/off switch, an automatic idle setting, two signed per-channel gains, and two interrupt configuration words that are only stored. The core's filter arithmetic, its serial port and its clock gating are outside the block. The block drives the core through plain level outputs and a single idle request.

The filter table holds 128 signed 16-bit taps. Software loads the whole table through one coefficient window. It first raises a load-enable bit in the control register, which rewinds the tap index. It then writes the 128 taps back to back. Each accepted write leaves the block as one write cycle on a coefficient RAM port. When the last tap has been accepted, a done flag rises. Software polls the flag and then drops the load-enable bit. The flag stays set until the next load begins.

Top module: `stc_regblock`

## Requirements
- R1: After reset, every register reads zero except the revision word at offset 0x00, which reads the parameter REV_VALUE. The done flag, the idle request and the coefficient write strobe are all low.
- R2: The control register sits at offset 0x2C. Bit 0 is the sidetone switch and drives st_enable. Bit 1 is the load enable. Both bits read back as written. Bit 2 reads the done flag, and writes to bit 2 have no effect.
- R3: The gain register sits at offset 0x24. Bits 15:0 are the channel 0 gain and drive ch0_gain. Bits 31:16 are the channel 1 gain and drive ch1_gain. The word reads back as written.
- R4: A write to the coefficient window at offset 0x28 is accepted while the load enable is set and fewer than 128 taps have been taken. In the cycle after the write edge, coef_we is high, coef_addr carries the current index, and coef_data carries write-data bits 15:0. The index then advances by one.
- R5: A write that changes the load enable from 0 to 1 rewinds the index to 0 and clears the done flag.
- R6: The done flag rises in the cycle after the 128th accepted tap, on both load_done and control bit 2. It stays set when the load enable is cleared, and falls only when the next 0-to-1 change of the load enable occurs.
- R7: A coefficient write is ignored while the load enable is clear or after 128 taps have been taken. In that case coef_we stays low and the index does not move.
- R8: The system register sits at offset 0x10, and its bit 0 is the auto-idle setting. idle_req is high exactly when auto-idle is set and the sidetone switch is off.
- R9: A read of offset 0x28 returns zero. Offsets 0x18 and 0x1C return the words last written to them. Unmapped offsets return zero.
- R10: Writing load enable = 1 while it is already 1 does not rewind the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| coef_we | output | 1 | Coefficient RAM write strobe |
| coef_addr | output | 7 | Coefficient RAM index |
| coef_data | output | 16 | Coefficient RAM data |
| load_done | output | 1 | All 128 taps have been loaded |
| st_enable | output | 1 | Sidetone switch |
| ch0_gain | output | 16 | Channel 0 gain |
| ch1_gain | output | 16 | Channel 1 gain |
| idle_req | output | 1 | Idle request to the clock controller |

## Verification
Each register write takes effect at the write edge. Read data, st_enable, the gains, idle_req and load_done are valid from that edge onward, so the bench reads them at the next falling edge. The coefficient RAM strobe, index and data are registered, so they appear for exactly the one cycle after the accepting edge. The bench captures them one nanosecond after that edge, then confirms that the strobe has dropped one cycle later. A bench model of the tap index predicts every RAM address, including across restarts, non-edge rewrites of the load enable, and writes that are ignored.

// File: rtl/stc_pkg.sv
package stc_pkg;

   // byte offsets decoded by the block
   localparam int unsigned OFS_REV   = 'h00;
   localparam int unsigned OFS_SYS   = 'h10;
   localparam int unsigned OFS_IRQS  = 'h18;
   localparam int unsigned OFS_IRQE  = 'h1C;
   localparam int unsigned OFS_GAIN  = 'h24;
   localparam int unsigned OFS_COEF  = 'h28;
   localparam int unsigned OFS_CTRL  = 'h2C;

   // control register bit positions
   localparam int unsigned CTL_ST_EN = 0;
   localparam int unsigned CTL_WEN   = 1;
   localparam int unsigned CTL_DONE  = 2;

   // system register bit positions
   localparam int unsigned SYS_AUTOIDLE = 0;

   typedef struct packed {
      logic rev;
      logic sys;
      logic irqs;
      logic irqe;
      logic gain;
      logic coef;
      logic ctrl;
   } stc_sel_t;

endpackage

// File: rtl/stc_decode.sv
module stc_decode
   import stc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output stc_sel_t          sel
);

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("stc_decode: ADDR_W must be at least 6");
      end
   endgenerate

   always_comb begin
      sel      = '0;
      sel.rev  = (addr == ADDR_W'(OFS_REV));
      sel.sys  = (addr == ADDR_W'(OFS_SYS));
      sel.irqs = (addr == ADDR_W'(OFS_IRQS));
      sel.irqe = (addr == ADDR_W'(OFS_IRQE));
      sel.gain = (addr == ADDR_W'(OFS_GAIN));
      sel.coef = (addr == ADDR_W'(OFS_COEF));
      sel.ctrl = (addr == ADDR_W'(OFS_CTRL));
   end

endmodule

// File: rtl/stc_cfg_regs.sv
module stc_cfg_regs
   import stc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GAIN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  stc_sel_t          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              st_en,
   output logic              wen,
   output logic              auto_idle,
   output logic [GAIN_W-1:0] gain0,
   output logic [GAIN_W-1:0] gain1,
   output logic [DATA_W-1:0] irq_stat,
   output logic [DATA_W-1:0] irq_en,
   output logic              load_start
);

   generate
      if (DATA_W < 2 * GAIN_W) begin : g_bad_gain
         $error("stc_cfg_regs: two gains must fit in one word");
      end
   endgenerate

   logic wr_ctrl;
   assign wr_ctrl    = bus_we && sel.ctrl;
   // a 0-to-1 change of the load enable starts a new table load
   assign load_start = wr_ctrl && wdata[CTL_WEN] && !wen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_en     <= 1'b0;
         wen       <= 1'b0;
         auto_idle <= 1'b0;
         gain0     <= '0;
         gain1     <= '0;
         irq_stat  <= '0;
         irq_en    <= '0;
      end else if (bus_we) begin
         if (sel.ctrl) begin
            st_en <= wdata[CTL_ST_EN];
            wen   <= wdata[CTL_WEN];
         end
         if (sel.sys)  auto_idle <= wdata[SYS_AUTOIDLE];
         if (sel.gain) begin
            gain0 <= wdata[GAIN_W-1:0];
            gain1 <= wdata[2*GAIN_W-1:GAIN_W];
         end
         if (sel.irqs) irq_stat <= wdata;
         if (sel.irqe) irq_en   <= wdata;
      end
   end

   AST_START_SETS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      load_start |=> wen); // R5

endmodule

// File: rtl/stc_coef_loader.sv
module stc_coef_loader #(
   parameter int unsigned DEPTH   = 128,
   parameter int unsigned COEF_W  = 16,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned IDX_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_start,
   input  logic              wen,
   input  logic              wr_strobe,
   input  logic [COEF_W-1:0] wdata,
   output logic              coef_we,
   output logic [IDX_W-1:0]  coef_addr,
   output logic [COEF_W-1:0] coef_data,
   output logic              done
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("stc_coef_loader: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             accept;

   assign done   = (cnt == CNT_W'(DEPTH));
   assign accept = wr_strobe && wen && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load_start) cnt <= '0;
      else if (accept)     cnt <= cnt + 1'b1;
   end

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               coef_we   <= 1'b0;
               coef_addr <= '0;
               coef_data <= '0;
            end else begin
               coef_we <= accept;
               if (accept) begin
                  coef_addr <= cnt[IDX_W-1:0];
                  coef_data <= wdata;
               end
            end
         end
      end else begin : g_out_comb
         assign coef_we   = accept;
         assign coef_addr = cnt[IDX_W-1:0];
         assign coef_data = wdata;
      end
   endgenerate

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R4
   AST_RESTART_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
      load_start |=> (cnt == '0 && !done)); // R5
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load_start) |=> done); // R6
   AST_IGNORED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && (!wen || done)) |=> $stable(cnt)); // R7

endmodule

// File: rtl/stc_regblock.sv
module stc_regblock
   import stc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned GAIN_W    = 16,
   parameter int unsigned COEF_W    = 16,
   parameter int unsigned DEPTH     = 128,
   parameter bit          OUT_REG   = 1'b1,
   parameter logic [31:0] REV_VALUE = 32'h0000_0031,
   localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              coef_we,
   output logic [IDX_W-1:0]  coef_addr,
   output logic [COEF_W-1:0] coef_data,
   output logic              load_done,
   output logic              st_enable,
   output logic [GAIN_W-1:0] ch0_gain,
   output logic [GAIN_W-1:0] ch1_gain,
   output logic              idle_req
);

   generate
      if (COEF_W > DATA_W || DATA_W < 3) begin : g_bad_width
         $error("stc_regblock: data word too narrow");
      end
   endgenerate

   stc_sel_t          sel;
   logic              wen, auto_idle, load_start;
   logic [DATA_W-1:0] irq_stat, irq_en;

   stc_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   stc_cfg_regs #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .sel        (sel),
      .wdata      (bus_wdata),
      .st_en      (st_enable),
      .wen        (wen),
      .auto_idle  (auto_idle),
      .gain0      (ch0_gain),
      .gain1      (ch1_gain),
      .irq_stat   (irq_stat),
      .irq_en     (irq_en),
      .load_start (load_start)
   );

   stc_coef_loader #(.DEPTH(DEPTH), .COEF_W(COEF_W), .OUT_REG(OUT_REG)) u_ld (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_start (load_start),
      .wen        (wen),
      .wr_strobe  (bus_we && sel.coef),
      .wdata      (bus_wdata[COEF_W-1:0]),
      .coef_we    (coef_we),
      .coef_addr  (coef_addr),
      .coef_data  (coef_data),
      .done       (load_done)
   );

   assign idle_req = auto_idle && !st_enable;

   always_comb begin
      bus_rdata = '0;
      unique case (1'b1)
         sel.rev:  bus_rdata = DATA_W'(REV_VALUE);
         sel.sys:  bus_rdata[SYS_AUTOIDLE] = auto_idle;
         sel.irqs: bus_rdata = irq_stat;
         sel.irqe: bus_rdata = irq_en;
         sel.gain: bus_rdata[2*GAIN_W-1:0] = {ch1_gain, ch0_gain};
         sel.ctrl: begin
            bus_rdata[CTL_ST_EN] = st_enable;
            bus_rdata[CTL_WEN]   = wen;
            bus_rdata[CTL_DONE]  = load_done;
         end
         default:  bus_rdata = '0;
      endcase
   end

   AST_NO_IDLE_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      st_enable |-> !idle_req); // R8
   AST_STROBE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && OUT_REG) |-> $past(wen)); // R7

endmodule

// File: tb/stc_regblock_bench.sv
module stc_regblock_bench;

   localparam logic [31:0] REV = 32'h0000_0031;
   localparam logic [7:0] A_REV = 8'h00, A_SYS = 8'h10, A_IRQS = 8'h18,
                          A_IRQE = 8'h1C, A_GAIN = 8'h24, A_COEF = 8'h28,
                          A_CTRL = 8'h2C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        coef_we;
   logic [6:0]  coef_addr;
   logic [15:0] coef_data;
   logic        load_done, st_enable, idle_req;
   logic [15:0] ch0_gain, ch1_gain;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic        cap_we;
   logic [6:0]  cap_addr;
   logic [15:0] cap_data;
   int          exp_idx = 0;

   always #2.5 clk = ~clk;

   stc_regblock u_stc_regblock (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .coef_we(coef_we),
      .coef_addr(coef_addr), .coef_data(coef_data), .load_done(load_done),
      .st_enable(st_enable), .ch0_gain(ch0_gain), .ch1_gain(ch1_gain),
      .idle_req(idle_req)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl_word(bit st, bit wen, bit done);
      return {29'd0, done, wen, st};
   endfunction

   // drive at falling edge, capture RAM port 1 ns after the write edge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1;
      cap_we = coef_we; cap_addr = coef_addr; cap_data = coef_data;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // one coefficient write; expectation from the bench index model
   task automatic coef_wr(logic [15:0] v, bit wen_set, string req);
      bit take;
      take = wen_set && (exp_idx < 128);
      wr(A_COEF, {16'hDEAD, v});
      chk(req, {31'd0, cap_we}, {31'd0, take});
      if (take) begin
         chk(req, {25'd0, cap_addr}, exp_idx);
         chk(req, {16'd0, cap_data}, {16'd0, v});
         exp_idx++;
      end
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r, g, x;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(A_REV, r);  chk("R1 rev", r, REV);
      rd(A_SYS, r);  chk("R1 sys", r, 0);
      rd(A_CTRL, r); chk("R1 ctrl", r, 0);
      rd(A_GAIN, r); chk("R1 gain", r, 0);
      rd(A_IRQE, r); chk("R1 irqe", r, 0);
      chk("R1 outs", {coef_we, load_done, idle_req, st_enable}, 0);

      // R8 idle request
      wr(A_SYS, 32'h1);
      @(negedge clk); chk("R8 idle on", idle_req, 1);
      wr(A_CTRL, ctrl_word(1, 0, 0));
      @(negedge clk); chk("R8 idle off while enabled", idle_req, 0);
      chk("R2 st_enable", st_enable, 1);
      rd(A_CTRL, r); chk("R2 ctrl readback", r, ctrl_word(1, 0, 0));
      wr(A_CTRL, 0);
      @(negedge clk); chk("R8 idle back", idle_req, 1);
      wr(A_SYS, 0);
      @(negedge clk); chk("R8 autoidle clear", idle_req, 0);

      // R2 done bit is read-only
      wr(A_CTRL, 32'h4);
      rd(A_CTRL, r); chk("R2 done not writable", r, 0);
      chk("R2 load_done port", load_done, 0);

      // R3 random gains
      for (int i = 0; i < 6; i++) begin
         g = $urandom;
         if (i == 0) g = 32'h8000_7FFF;
         wr(A_GAIN, g);
         @(negedge clk);
         chk("R3 ch0", {16'd0, ch0_gain}, {16'd0, g[15:0]});
         chk("R3 ch1", {16'd0, ch1_gain}, {16'd0, g[31:16]});
         rd(A_GAIN, r); chk("R3 readback", r, g);
      end

      // R9 other reads
      x = $urandom; wr(A_IRQS, x); rd(A_IRQS, r); chk("R9 irqs", r, x);
      x = $urandom; wr(A_IRQE, x); rd(A_IRQE, r); chk("R9 irqe", r, x);
      rd(A_COEF, r); chk("R9 coef reads zero", r, 0);
      rd(8'h04, r);  chk("R9 unmapped", r, 0);

      // R7 coefficient write while load enable clear
      coef_wr(16'h1234, 0, "R7 wen clear");
      @(negedge clk); chk("R7 no strobe", coef_we, 0);

      // R4/R5 start a load
      wr(A_CTRL, ctrl_word(0, 1, 0)); exp_idx = 0;
      for (int i = 0; i < 5; i++) coef_wr(16'($urandom), 1, "R4 partial");
      @(negedge clk); chk("R4 strobe one cycle", coef_we, 0);
      // R10 rewrite of load enable already set keeps index
      wr(A_CTRL, ctrl_word(0, 1, 0));
      coef_wr(16'h00A5, 1, "R10 no rewind");
      // R5 a true 0->1 edge rewinds
      wr(A_CTRL, 0);
      wr(A_CTRL, ctrl_word(0, 1, 0)); exp_idx = 0;
      for (int i = 0; i < 127; i++) coef_wr(16'($urandom), 1, "R4 full");
      @(negedge clk); chk("R6 not done at 127", load_done, 0);
      coef_wr(16'h8000, 1, "R4 last");
      @(negedge clk); chk("R6 done at 128", load_done, 1);
      rd(A_CTRL, r); chk("R6 ctrl done", r, ctrl_word(0, 1, 1));
      coef_wr(16'h7777, 1, "R7 past 128");
      @(negedge clk); chk("R7 still done", load_done, 1);
      wr(A_CTRL, 0);
      rd(A_CTRL, r); chk("R6 done held after wen clear", r, ctrl_word(0, 0, 1));
      wr(A_CTRL, ctrl_word(1, 1, 0)); exp_idx = 0;
      rd(A_CTRL, r); chk("R5 done cleared", r, ctrl_word(1, 1, 0));
      coef_wr(16'h0F0F, 1, "R5 restart index");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule